// File: doc/BRIEF.md
# Video Decoder Serial Control Port

This block is the two-wire serial slave through which a host configures a multistandard video decoder and reads back its state. The host addresses the block, sends a register index, and then streams data bytes that land in consecutive control registers. A read returns a single status byte that gathers the decoder's lock, field rate, input mode, port pin and colour standard indications together with a power-on flag.

The block enforces a start-up order. After reset the power-on flag reads 1. The crystal indication sits in register 0, and it must be loaded before register 1 is written, because that write starts line-oscillator calibration. Calibration starts only when register 0 has already been written. The power-on flag clears on the first status read that follows a write which started calibration. SCL and SDA pass through a synchroniser into the system clock domain, and all protocol handling runs on that clock. SDA is open-drain and appears as an input plus a pull-low enable.

Top module: `vdec_ctrl_regs`

## Requirements
- R1: The block acknowledges the 7-bit address 0x45 (write byte 0x8A) when `addr_strap` is 0 and 0x47 (write byte 0x8E) when it is 1. Only address bit 1 follows the strap. Any other address gets no acknowledge, `sda_oe` stays 0, and the block ignores the rest of that transfer.
- R2: After the address byte of a write, the next byte is the register index, and only its low 4 bits are kept. The index increments after every data byte in the transfer and wraps from 0x0F to 0x00.
- R3: Register 0 drives, MSB to LSB: `src_sel`[1:0], `trap_bypass`, `comb_en`, `loop_tc`[1:0], `xtal_cfg`[1:0].
- R4: Register 1 drives, MSB to LSB: `field_force`[1:0], `io_port_val`, `out_port_val`, `loop_open`, `std_forced`, `std_secam`, `xtal_ref`. Register 2 drives `fast_sw_en` (bit 7), `search_tune` (bit 6) and `hue`[5:0]. Bit 7 of register 3 drives `llc_mode`.
- R5: Data bytes written to indices 0x04 to 0x0F are acknowledged but change no control output.
- R6: A read sends the status byte MSB first: power-on flag, `fld_60hz_i`, `yc_mode_i`, `h_lock_i`, `io_pin_i`, `std_code_i`[2:0]. The status byte is sent again for each further byte the master acknowledges, whatever index was last written.
- R7: `cal_start` pulses high for exactly one clock on a write to register 1, but only if register 0 has been written since reset. A write to register 1 before any write to register 0 raises no pulse.
- R8: `por_flag` is 1 after reset. It clears at the ninth SCL rise of a status byte read that follows a write that raised `cal_start`. Once cleared, it stays 0 until reset. Reads made before such a write leave it at 1.
- R9: During and after reset, every control output, `cal_start` and `sda_oe` are 0.
- R10: A START at any point begins a new address phase. A STOP at any point ends the transfer, and a byte that was cut short writes nothing.
- R11: Each data byte reaches its control outputs while the block is acknowledging that byte, before the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_strap | input | 1 | Slave address select |
| fld_60hz_i | input | 1 | Field rate indication, 1 = 60 Hz |
| yc_mode_i | input | 1 | Input mode indication, 1 = Y/C |
| h_lock_i | input | 1 | Line loop locked |
| io_pin_i | input | 1 | I/O port pin level |
| std_code_i | input | 3 | Detected standard code |
| src_sel | output | 2 | Source select |
| trap_bypass | output | 1 | Chroma trap bypass |
| comb_en | output | 1 | Comb filter enable |
| loop_tc | output | 2 | Line loop time constant select |
| xtal_cfg | output | 2 | Fitted crystal indication |
| field_force | output | 2 | Forced field frequency |
| io_port_val | output | 1 | I/O port drive value |
| out_port_val | output | 1 | Output port value |
| loop_open | output | 1 | Open the line loop |
| std_forced | output | 1 | Forced standard mode |
| std_secam | output | 1 | SECAM versus PAL/NTSC when forced |
| xtal_ref | output | 1 | Crystal select when forced |
| fast_sw_en | output | 1 | Fast switch enable |
| search_tune | output | 1 | Search tuning mode |
| hue | output | 6 | Hue code |
| llc_mode | output | 1 | Line-locked clock mode |
| cal_start | output | 1 | Line oscillator calibration strobe |
| por_flag | output | 1 | Power-on flag |

## Verification
The bench uses the default parameters: four control registers, a two-stage synchroniser, base address 0x45 and strap on address bit 1. With only four implemented registers in a 16-entry index space, a short burst reaches the discard range 0x04–0x0F and the wrap from 0x0F back to register 0. The start-up order is run in both sequences, register 1 before register 0 and the reverse, and multi-byte reads show the power-on flag changing between two consecutive status bytes.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

    localparam int SUB_W    = 4;
    localparam int XTAL_SUB = 0;
    localparam int CAL_SUB  = 1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_SUB,
        S_SUB_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } i2c_st_e;

    typedef struct packed {
        i2c_st_e          st;
        logic [7:0]       sh;
        logic [2:0]       cnt;
        logic             full;
        logic             is_read;
        logic [SUB_W-1:0] sub;
        logic             sda_oe;
        logic             wr_en;
        logic [SUB_W-1:0] wr_addr;
        logic [7:0]       wr_data;
        logic             rd_done;
        logic             mack;
    } fsm_s;

endpackage

// File: rtl/vdc_line_sync.sv
module vdc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_last;
        logic              sda_last;
    } sync_s;

    sync_s q, d;

    always_comb begin
        d          = q;
        d.scl_ff   = {q.scl_ff[STAGES-2:0], scl_i};
        d.sda_ff   = {q.sda_ff[STAGES-2:0], sda_i};
        d.scl_last = q.scl_ff[STAGES-1];
        d.sda_last = q.sda_ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_ff[STAGES-1];
    assign sda_s     = q.sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_last;
    assign scl_fall  = ~scl_s & q.scl_last;
    assign start_det = scl_s & q.scl_last & q.sda_last & ~sda_s;
    assign stop_det  = scl_s & q.scl_last & ~q.sda_last & sda_s;

endmodule

// File: rtl/vdc_i2c_fsm.sv
module vdc_i2c_fsm
    import vdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       status_byte,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [SUB_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             rd_done
);

    fsm_s q, d;

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.rd_done = 1'b0;
        if (stop_det) begin
            d.st     = S_IDLE;
            d.sda_oe = 1'b0;
            d.full   = 1'b0;
        end else if (start_det) begin
            d.st     = S_ADDR;
            d.cnt    = '0;
            d.full   = 1'b0;
            d.sda_oe = 1'b0;
        end else begin
            case (q.st)
                S_ADDR, S_SUB, S_WDATA: begin
                    if (scl_rise && !q.full) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.full = 1'b1;
                    end
                    if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.cnt  = '0;
                        if (q.st == S_ADDR) begin
                            if (q.sh[7:1] == dev_addr) begin
                                d.st      = S_ADDR_ACK;
                                d.sda_oe  = 1'b1;
                                d.is_read = q.sh[0];
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else if (q.st == S_SUB) begin
                            d.sub    = q.sh[SUB_W-1:0];
                            d.st     = S_SUB_ACK;
                            d.sda_oe = 1'b1;
                        end else begin
                            d.wr_en   = 1'b1;
                            d.wr_addr = q.sub;
                            d.wr_data = q.sh;
                            d.sub     = q.sub + 1'b1;
                            d.st      = S_WDATA_ACK;
                            d.sda_oe  = 1'b1;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (q.is_read) begin
                            d.st     = S_RDATA;
                            d.sh     = status_byte;
                            d.sda_oe = ~status_byte[7];
                            d.cnt    = '0;
                        end else begin
                            d.st     = S_SUB;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                S_SUB_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.st     = S_WDATA;
                        d.sda_oe = 1'b0;
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.st     = S_RACK;
                            d.sda_oe = 1'b0;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.cnt    = q.cnt + 3'd1;
                            d.sda_oe = ~q.sh[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        d.mack    = ~sda_s;
                        d.rd_done = 1'b1;
                    end
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.st     = S_RDATA;
                            d.sh     = status_byte;
                            d.sda_oe = ~status_byte[7];
                            d.cnt    = '0;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.sda_oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign rd_done = q.rd_done;

    // R1: the slave only moves SDA while SCL is low
    p_sda_edge_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_oe) |-> !scl_s);

    // R11: register writes land during the low phase of the ACK bit
    p_write_in_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (!scl_s && q.sda_oe));

    // R6: status bytes are only shifted out after a read address
    p_drive_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RDATA) |-> q.is_read);

endmodule

// File: rtl/vdc_regfile.sv
module vdc_regfile
    import vdc_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SUB_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  rd_done,
    output logic [NUM_REGS*8-1:0] ctrl_flat,
    output logic                  cal_start,
    output logic                  por_flag
);

    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] regs;
        logic                     xtal_loaded;
        logic                     cal_armed;
        logic                     por;
        logic                     cal;
    } rf_s;

    rf_s q, d;

    always_comb begin
        d     = q;
        d.cal = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (wr_addr == SUB_W'(i))) d.regs[i] = wr_data;
        end
        if (wr_en && (wr_addr == SUB_W'(XTAL_SUB))) d.xtal_loaded = 1'b1;
        if (wr_en && (wr_addr == SUB_W'(CAL_SUB)) && q.xtal_loaded) begin
            d.cal       = 1'b1;
            d.cal_armed = 1'b1;
        end
        if (rd_done && q.cal_armed) d.por = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.por <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ctrl_flat = q.regs;
    assign cal_start = q.cal;
    assign por_flag  = q.por;

    // R7: calibration strobe is a single clock wide
    p_cal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cal |=> !q.cal);

    // R7: calibration only after the crystal indication was loaded
    p_cal_needs_xtal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cal |-> q.xtal_loaded);

    // R8: once cleared the power-on flag never returns without reset
    p_por_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.por |=> !q.por);

    // R8: a status read after calibration clears the flag
    p_por_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && q.cal_armed) |=> !q.por);

    // R5: registers hold between writes
    p_reg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q.regs));

endmodule

// File: rtl/vdec_ctrl_regs.sv
module vdec_ctrl_regs
    import vdc_pkg::*;
#(
    parameter int         NUM_CTRL_REGS = 4,
    parameter int         SYNC_STAGES   = 2,
    parameter logic [6:0] DEV_ADDR_LOW  = 7'h45,
    parameter int         STRAP_BIT     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_strap,
    input  logic       fld_60hz_i,
    input  logic       yc_mode_i,
    input  logic       h_lock_i,
    input  logic       io_pin_i,
    input  logic [2:0] std_code_i,
    output logic [1:0] src_sel,
    output logic       trap_bypass,
    output logic       comb_en,
    output logic [1:0] loop_tc,
    output logic [1:0] xtal_cfg,
    output logic [1:0] field_force,
    output logic       io_port_val,
    output logic       out_port_val,
    output logic       loop_open,
    output logic       std_forced,
    output logic       std_secam,
    output logic       xtal_ref,
    output logic       fast_sw_en,
    output logic       search_tune,
    output logic [5:0] hue,
    output logic       llc_mode,
    output logic       cal_start,
    output logic       por_flag
);

    localparam int CTRL_W = NUM_CTRL_REGS * 8;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en, rd_done;
    logic [SUB_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [7:0]       status_byte;
    logic [6:0]       dev_addr;
    logic [CTRL_W-1:0] ctrl_flat;
    logic             unused_sub3;

    assign dev_addr    = DEV_ADDR_LOW | (7'(addr_strap) << STRAP_BIT);
    assign status_byte = {por_flag, fld_60hz_i, yc_mode_i, h_lock_i, io_pin_i, std_code_i};

    vdc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    vdc_i2c_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .status_byte(status_byte),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_done(rd_done)
    );

    vdc_regfile #(.NUM_REGS(NUM_CTRL_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_done(rd_done), .ctrl_flat(ctrl_flat),
        .cal_start(cal_start), .por_flag(por_flag)
    );

    assign {src_sel, trap_bypass, comb_en, loop_tc, xtal_cfg} = ctrl_flat[7:0];
    assign {field_force, io_port_val, out_port_val, loop_open,
            std_forced, std_secam, xtal_ref}                  = ctrl_flat[15:8];
    assign {fast_sw_en, search_tune, hue}                     = ctrl_flat[23:16];
    assign llc_mode    = ctrl_flat[31];
    assign unused_sub3 = ^ctrl_flat[30:24];

    // R10: a STOP releases the data line on the next clock
    p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

// File: tb/test_vdec_ctrl_regs.sv
module test_vdec_ctrl_regs;

    localparam int Q = 10;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_lo = 1'b0;
    logic strap = 1'b0;
    logic fld60 = 1'b1, yc = 1'b0, lock = 1'b1, iop = 1'b0;
    logic [2:0] stdc = 3'b101;

    logic sda_oe, cal_start, por_flag;
    logic [1:0] src_sel, loop_tc, xtal_cfg, field_force;
    logic trap_bypass, comb_en, io_port_val, out_port_val, loop_open;
    logic std_forced, std_secam, xtal_ref, fast_sw_en, search_tune, llc_mode;
    logic [5:0] hue;
    wire  sda_line = !(sda_lo || sda_oe);

    int n_chk = 0, n_fail = 0, cal_cnt = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    vdec_ctrl_regs i_vdec_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_strap(strap), .fld_60hz_i(fld60), .yc_mode_i(yc), .h_lock_i(lock),
        .io_pin_i(iop), .std_code_i(stdc), .src_sel(src_sel), .trap_bypass(trap_bypass),
        .comb_en(comb_en), .loop_tc(loop_tc), .xtal_cfg(xtal_cfg), .field_force(field_force),
        .io_port_val(io_port_val), .out_port_val(out_port_val), .loop_open(loop_open),
        .std_forced(std_forced), .std_secam(std_secam), .xtal_ref(xtal_ref),
        .fast_sw_en(fast_sw_en), .search_tune(search_tune), .hue(hue), .llc_mode(llc_mode),
        .cal_start(cal_start), .por_flag(por_flag)
    );

    wire [24:0] view = {src_sel, trap_bypass, comb_en, loop_tc, xtal_cfg,
                        field_force, io_port_val, out_port_val, loop_open,
                        std_forced, std_secam, xtal_ref,
                        fast_sw_en, search_tune, hue, llc_mode};

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] status(logic por);
        return {por, fld60, yc, lock, iop, stdc};
    endfunction

    always @(negedge clk) if (cal_start) cal_cnt++;

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), 32'(got_q.pop_front()), 32'(exp_q.pop_front()));
        end
    end

    task automatic bus_start();
        if (!scl_m) begin
            sda_lo = 1'b0; tick(Q);
            scl_m = 1'b1;  tick(Q);
        end
        sda_lo = 1'b1; tick(H);
        scl_m = 1'b0;  tick(Q);
    endtask

    task automatic bus_stop();
        sda_lo = 1'b1; tick(Q);
        scl_m = 1'b1;  tick(Q);
        sda_lo = 1'b0; tick(H);
    endtask

    task automatic send_bit(logic b);
        sda_lo = !b;  tick(Q);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_lo = 1'b0; tick(Q);
        scl_m = 1'b1;  tick(Q);
        ack = !sda_line; tick(Q);
        scl_m = 1'b0;  tick(Q);
    endtask

    task automatic rd_byte(logic [7:0] exp, string tag, logic give_ack);
        logic [7:0] v;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        sda_lo = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            v[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_lo = give_ack; tick(Q);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
        sda_lo = 1'b0;
        got_q.push_back(v);
    endtask

    // write transfer: address byte, index, then n data bytes
    task automatic wr_xfer(logic [6:0] a, logic [7:0] idx, logic [7:0] d0, logic [7:0] d1,
                           int n, string tag);
        logic ack;
        bus_start();
        wr_byte({a, 1'b0}, ack); chk({tag, " addr ack"}, 32'(ack), 1);
        wr_byte(idx, ack);       chk({tag, " index ack"}, 32'(ack), 1);
        if (n > 0) begin wr_byte(d0, ack); chk({tag, " d0 ack"}, 32'(ack), 1); end
        if (n > 1) begin wr_byte(d1, ack); chk({tag, " d1 ack"}, 32'(ack), 1); end
        bus_stop();
    endtask

    task automatic rd_xfer(logic [6:0] a, logic [7:0] e0, logic [7:0] e1, int n, string tag);
        logic ack;
        bus_start();
        wr_byte({a, 1'b1}, ack); chk({tag, " read addr ack"}, 32'(ack), 1);
        rd_byte(e0, {tag, " status byte0"}, n > 1);
        if (n > 1) rd_byte(e1, {tag, " status byte1"}, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [24:0] snap;
        tick(4);
        chk("R9 reset view", 32'(view), 0);
        chk("R9 reset sda_oe", 32'(sda_oe), 0);
        chk("R9 reset cal", 32'(cal_start), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R8 por after reset", 32'(por_flag), 1);

        // R6 R8: status read before any write
        rd_xfer(7'h45, status(1'b1), 8'h00, 1, "R6");

        // R7: write 01 before 00 gives no calibration
        wr_xfer(7'h45, 8'h01, 8'h5A, 8'h00, 1, "R7 early");
        tick(4);
        chk("R7 no cal before xtal", 32'(cal_cnt), 0);
        chk("R4 reg1 fields", 32'(view[16:9]), 32'h5A);
        rd_xfer(7'h45, status(1'b1), 8'h00, 1, "R8 por kept");
        chk("R8 por still set", 32'(por_flag), 1);

        // R2 R3 R11: burst from index 0
        bus_start();
        wr_byte(8'h8A, ack); chk("R1 low strap ack", 32'(ack), 1);
        wr_byte(8'h00, ack);
        wr_byte(8'hC9, ack);
        chk("R11 reg0 before stop", 32'(view[24:17]), 32'hC9);
        wr_byte(8'hA6, ack);
        wr_byte(8'h7F, ack);
        wr_byte(8'h80, ack);
        bus_stop();
        chk("R7 cal after xtal", 32'(cal_cnt), 1);
        chk("R2 R3 burst view", 32'(view), 32'({8'hC9, 8'hA6, 8'h7F, 1'b1}));
        chk("R3 src_sel", 32'(src_sel), 3);
        chk("R3 xtal_cfg", 32'(xtal_cfg), 1);
        chk("R4 hue", 32'(hue), 32'h3F);
        chk("R4 llc", 32'(llc_mode), 1);

        // R8: two-byte read, flag drops between bytes
        rd_xfer(7'h45, status(1'b1), status(1'b0), 2, "R8 clear");
        chk("R8 por cleared", 32'(por_flag), 0);

        // R6 R10: new status pattern, index set then repeated start read
        yc = 1'b1; iop = 1'b1; stdc = 3'b010;
        bus_start();
        wr_byte(8'h8A, ack);
        wr_byte(8'h03, ack);
        bus_start();
        wr_byte(8'h8B, ack); chk("R10 repeated start ack", 32'(ack), 1);
        rd_byte(8'h7A, "R6 status any index", 1'b0);
        bus_stop();

        // R5: discard range
        snap = view;
        wr_xfer(7'h45, 8'h04, 8'hFF, 8'hFF, 2, "R5");
        chk("R5 discard no change", 32'(view), 32'(snap));

        // R2: wrap 0F -> 00
        wr_xfer(7'h45, 8'h0F, 8'h11, 8'h22, 2, "R2 wrap");
        chk("R2 wrap lands reg0", 32'(view[24:17]), 32'h22);
        chk("R5 index 0F discarded", 32'(view[16:1]), 32'hA67F);

        // R1: wrong addresses
        snap = view;
        bus_start();
        wr_byte(8'h88, ack); chk("R1 other addr nack", 32'(ack), 0);
        wr_byte(8'h00, ack); chk("R1 ignored index nack", 32'(ack), 0);
        wr_byte(8'h00, ack);
        bus_stop();
        bus_start();
        wr_byte(8'h8E, ack); chk("R1 strap-high addr nack while low", 32'(ack), 0);
        bus_stop();
        chk("R1 ignored view", 32'(view), 32'(snap));

        // R10: stop in mid byte writes nothing
        bus_start();
        wr_byte(8'h8A, ack);
        wr_byte(8'h02, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        chk("R10 cut byte no write", 32'(view), 32'(snap));

        // R1 strap high, R7 repeated calibration
        strap = 1'b1;
        tick(4);
        bus_start();
        wr_byte(8'h8A, ack); chk("R1 low addr nack with strap", 32'(ack), 0);
        bus_stop();
        wr_xfer(7'h47, 8'h02, 8'h95, 8'h00, 1, "R1 strap high");
        chk("R4 reg2 via strap addr", 32'(view[8:1]), 32'h95);
        wr_xfer(7'h47, 8'h01, 8'h03, 8'h00, 1, "R7 again");
        chk("R7 second cal", 32'(cal_cnt), 2);
        chk("R4 xtal_ref", 32'(xtal_ref), 1);

        tick(10);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule